// File: doc/BRIEF.md
# Block-Release Receive Byte Pool

This block buffers received bytes between a serial frame receiver and a CPU. The receiver pushes one byte per cycle and marks the last byte of each frame. The pool cuts each frame into blocks whose size is set by a two-bit threshold code. Each full block that does not end a frame raises a pool-full interrupt. The block that closes a frame raises a message-end interrupt instead, and it publishes the frame's total length and the length of its partial tail.

The CPU reads the offered block through a show-ahead read port. A count output tells it how many bytes of the block are left to read. It then issues a release command, which frees the block's storage and lets the next block be offered. A receiver-reset command empties the pool and loads a new threshold code.

Blocks are offered strictly in arrival order and one at a time. Both interrupt flags stay set until the CPU acknowledges them.

Top module: `rxpool_fifo`

## Requirements
- R1: The threshold code selects the block size: 2'b00 gives 4 bytes, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 60. Reset loads 2'b10. A receiver-reset command loads `thr_sel`. At any other time a change of `thr_sel` has no effect.
- R2: When a threshold's worth of bytes has arrived and the block does not end a frame, `irq_pf` rises. At that point `rd_left` equals the threshold. `rd_data` shows the bytes in write order, and each accepted `rd_en` advances it by one byte.
- R3: When the last byte of a frame arrives, `irq_me` rises. `byte_cnt` then holds the frame length, `tail_cnt` holds the length modulo the threshold, and `rd_left` equals `tail_cnt`.
- R4: When a frame's length is an exact multiple of the threshold, its final block raises only `irq_me`. In that case `tail_cnt` reads 0 and `rd_left` equals the threshold.
- R5: At most one block is offered at a time. No further interrupt is raised until the offered block is released. Storage is freed only by a release.
- R6: `irq_pf` is cleared only by `ack_pf`, and `irq_me` is cleared only by `ack_me`. Acknowledging one flag leaves the other untouched.
- R7: An `rd_en` while `rd_left` is 0 is ignored: `rd_data` and `rd_left` do not change.
- R8: A release moves to the next block even if some bytes are unread, and the unread bytes are discarded. A release while no block is offered is ignored.
- R9: The pool holds 64 unreleased bytes. A byte written while the pool is full is dropped, is not counted and sets the sticky `overflow` flag.
- R10: A receiver-reset command clears the stored bytes, both flags, `overflow`, `byte_cnt`, `tail_cnt` and `rd_left`.
- R11: `byte_cnt` and `tail_cnt` keep their values through acknowledge and release until the next message end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_sel | input | 2 | Threshold code, loaded on receiver reset |
| cmd_rx_reset | input | 1 | Receiver-reset command |
| wr_valid | input | 1 | Receiver byte strobe |
| wr_data | input | 8 | Received byte |
| wr_last | input | 1 | Byte ends the frame |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 8 | Show-ahead read byte |
| rd_left | output | 7 | Bytes left to read in the offered block |
| cmd_release | input | 1 | Release the offered block |
| ack_pf | input | 1 | Acknowledge pool-full |
| ack_me | input | 1 | Acknowledge message-end |
| irq_pf | output | 1 | Pool-full interrupt flag |
| irq_me | output | 1 | Message-end interrupt flag |
| byte_cnt | output | 16 | Length of the last completed frame |
| tail_cnt | output | 7 | Frame length modulo threshold |
| overflow | output | 1 | Sticky dropped-byte flag |

## Verification
The bench builds the pool with its default 64-byte depth. At that depth a full pool and the dropped-byte path are reached after a few dozen writes. The bench selects each of the four threshold codes in turn. For every code it runs every frame length from 1 to twice the threshold plus one, and then one frame of 200 bytes. It predicts each interrupt, count and byte arithmetically, which covers short frames, frames on exact multiples and frames one byte past them. Directed sequences cover blocks queued behind an unreleased one, one-sided acknowledges, surplus reads, partial reads before a release, and a receiver reset in the middle of a frame.

// File: rtl/rxpool_pkg.sv
`timescale 1ns/1ps
package rxpool_pkg;
    localparam int BW = 8;   // byte width
    localparam int LW = 7;   // block length width, covers up to 64
    localparam int CW = 16;  // frame byte count width

    typedef logic [1:0]    thr_code_t;
    typedef logic [LW-1:0] blen_t;
    typedef logic [CW-1:0] fcnt_t;
    typedef logic [BW-1:0] byte_t;

    localparam thr_code_t THR_AT_RESET = 2'b10;

    // one queued block descriptor produced on the write side
    typedef struct packed {
        logic  is_end;   // block closes a frame
        blen_t len;      // bytes in this block
        fcnt_t total;    // frame length, valid when is_end
    } blk_ev_t;

    function automatic blen_t thr_bytes(input thr_code_t code);
        case (code)
            2'b00:   return blen_t'(4);
            2'b01:   return blen_t'(16);
            2'b10:   return blen_t'(32);
            default: return blen_t'(60);
        endcase
    endfunction
endpackage

// File: rtl/rxpool_store.sv
`timescale 1ns/1ps
module rxpool_store
    import rxpool_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic            clk,
    input  logic            flush,
    input  logic            wr_valid,
    input  byte_t           wr_data,
    input  logic            rd_step,
    input  logic            rel_fire,
    input  blen_t           rel_len,
    output logic            acc,
    output byte_t           rd_data,
    output logic [$clog2(DEPTH):0] used
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] FULL_LVL = (PW+1)'(DEPTH);

    byte_t       mem [DEPTH];
    logic [PW:0] wr_ptr, rd_ptr, rel_ptr;
    logic [PW:0] rel_ext;

    assign rel_ext = (PW+1)'(rel_len);
    assign used    = wr_ptr - rel_ptr;
    assign acc     = wr_valid && (used != FULL_LVL);
    assign rd_data = mem[rd_ptr[PW-1:0]];

    always_ff @(posedge clk) begin
        if (acc) mem[wr_ptr[PW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            rel_ptr <= '0;
        end else begin
            if (acc) wr_ptr <= wr_ptr + 1'b1;
            if (rel_fire) begin
                rel_ptr <= rel_ptr + rel_ext;
                rd_ptr  <= rel_ptr + rel_ext;
            end else if (rd_step) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    // R9: unreleased bytes never exceed the pool size
    a_r9_used_bound: assert property (@(posedge clk) disable iff (flush)
        used <= FULL_LVL);
    // R8: read pointer stays inside the unreleased region
    a_r8_rd_inside: assert property (@(posedge clk) disable iff (flush)
        (rd_ptr - rel_ptr) <= used);
endmodule

// File: rtl/rxpool_seg.sv
`timescale 1ns/1ps
module rxpool_seg
    import rxpool_pkg::*;
(
    input  logic    clk,
    input  logic    flush,
    input  blen_t   thr,
    input  logic    acc,
    input  logic    last,
    output logic    ev_push,
    output blk_ev_t ev
);
    blen_t seg_cnt, seg_nx;
    fcnt_t frame_cnt, frm_nx;

    always_comb begin
        seg_nx   = seg_cnt + 1'b1;
        frm_nx   = frame_cnt + 1'b1;
        ev_push  = acc && (last || (seg_nx == thr));
        ev.is_end = last;
        ev.len    = seg_nx;
        ev.total  = frm_nx;
    end

    always_ff @(posedge clk) begin
        if (flush) begin
            seg_cnt   <= '0;
            frame_cnt <= '0;
        end else if (acc) begin
            if (last) begin
                seg_cnt   <= '0;
                frame_cnt <= '0;
            end else begin
                seg_cnt   <= (seg_nx == thr) ? '0 : seg_nx;
                frame_cnt <= frm_nx;
            end
        end
    end

    // R2: a partial segment is always shorter than a block
    a_r2_seg_below_thr: assert property (@(posedge clk) disable iff (flush)
        seg_cnt < thr);
endmodule

// File: rtl/rxpool_evq.sv
`timescale 1ns/1ps
module rxpool_evq
    import rxpool_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic    clk,
    input  logic    flush,
    input  logic    push,
    input  blk_ev_t din,
    input  logic    pop,
    output logic    empty,
    output blk_ev_t head
);
    localparam int QW = $clog2(DEPTH);
    localparam logic [QW:0]   Q_FULL = (QW+1)'(DEPTH);
    localparam logic [QW-1:0] Q_LAST = QW'(DEPTH-1);

    blk_ev_t       q [DEPTH];
    logic [QW-1:0] wrp, rdp;
    logic [QW:0]   cnt;

    assign empty = (cnt == '0);
    assign head  = q[rdp];

    always_ff @(posedge clk) begin
        if (push) q[wrp] <= din;
    end

    always_ff @(posedge clk) begin
        if (flush) begin
            wrp <= '0;
            rdp <= '0;
            cnt <= '0;
        end else begin
            if (push) wrp <= (wrp == Q_LAST) ? '0 : wrp + 1'b1;
            if (pop)  rdp <= (rdp == Q_LAST) ? '0 : rdp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R5: descriptors never overrun or underrun the queue
    a_r5_evq_no_overrun: assert property (@(posedge clk) disable iff (flush)
        (push && !pop) |-> (cnt != Q_FULL));
    a_r5_evq_no_underrun: assert property (@(posedge clk) disable iff (flush)
        pop |-> (cnt != '0));
endmodule

// File: rtl/rxpool_present.sv
`timescale 1ns/1ps
module rxpool_present
    import rxpool_pkg::*;
(
    input  logic    clk,
    input  logic    flush,
    input  blen_t   thr,
    input  logic    ev_empty,
    input  blk_ev_t ev_head,
    input  logic    cmd_release,
    input  logic    rd_en,
    input  logic    ack_pf,
    input  logic    ack_me,
    output logic    ev_pop,
    output logic    rd_step,
    output logic    rel_fire,
    output blen_t   rel_len,
    output blen_t   rd_left,
    output logic    irq_pf,
    output logic    irq_me,
    output fcnt_t   byte_cnt,
    output blen_t   tail_cnt
);
    logic  blk_open;
    blen_t blk_len, rd_done;

    always_comb begin
        ev_pop   = !blk_open && !ev_empty;
        rel_fire = blk_open && cmd_release;
        rd_step  = blk_open && rd_en && !cmd_release && (rd_done != blk_len);
        rel_len  = blk_len;
        rd_left  = blk_open ? (blk_len - rd_done) : '0;
    end

    always_ff @(posedge clk) begin
        if (flush) begin
            blk_open <= 1'b0;
            blk_len  <= '0;
            rd_done  <= '0;
            irq_pf   <= 1'b0;
            irq_me   <= 1'b0;
            byte_cnt <= '0;
            tail_cnt <= '0;
        end else begin
            irq_pf <= (irq_pf && !ack_pf) || (ev_pop && !ev_head.is_end);
            irq_me <= (irq_me && !ack_me) || (ev_pop &&  ev_head.is_end);
            if (ev_pop) begin
                blk_open <= 1'b1;
                blk_len  <= ev_head.len;
                rd_done  <= '0;
                if (ev_head.is_end) begin
                    byte_cnt <= ev_head.total;
                    tail_cnt <= (ev_head.len == thr) ? '0 : ev_head.len;
                end
            end else if (rel_fire) begin
                blk_open <= 1'b0;
                rd_done  <= '0;
            end else if (rd_step) begin
                rd_done <= rd_done + 1'b1;
            end
        end
    end

    // R7: reads never pass the end of the offered block
    a_r7_rd_bounded: assert property (@(posedge clk) disable iff (flush)
        rd_done <= blk_len);
    // R2: a fresh pool-full always comes with an offered block
    a_r2_pf_has_block: assert property (@(posedge clk) disable iff (flush)
        $rose(irq_pf) |-> blk_open);
    // R6: flags hold until their own acknowledge
    a_r6_pf_sticky: assert property (@(posedge clk) disable iff (flush)
        (irq_pf && !ack_pf) |=> irq_pf);
    a_r6_me_sticky: assert property (@(posedge clk) disable iff (flush)
        (irq_me && !ack_me) |=> irq_me);
    // R11: published counts move only when a frame-end block is offered
    a_r11_cnt_hold: assert property (@(posedge clk) disable iff (flush)
        !(ev_pop && ev_head.is_end) |=> $stable(byte_cnt));
endmodule

// File: rtl/rxpool_fifo.sv
`timescale 1ns/1ps
module rxpool_fifo
    import rxpool_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  thr_sel,
    input  logic        cmd_rx_reset,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        wr_last,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    output logic [6:0]  rd_left,
    input  logic        cmd_release,
    input  logic        ack_pf,
    input  logic        ack_me,
    output logic        irq_pf,
    output logic        irq_me,
    output logic [15:0] byte_cnt,
    output logic [6:0]  tail_cnt,
    output logic        overflow
);
    localparam int PW = $clog2(DEPTH);

    thr_code_t   thr_q;
    blen_t       thr_b;
    logic        flush;
    logic        acc, ev_push, ev_pop, ev_empty;
    logic        rd_step, rel_fire;
    blen_t       rel_len;
    blk_ev_t     ev_in, ev_head;
    logic [PW:0] used;

    assign flush = rst || cmd_rx_reset;
    assign thr_b = thr_bytes(thr_q);

    always_ff @(posedge clk) begin
        if (rst)               thr_q <= THR_AT_RESET;
        else if (cmd_rx_reset) thr_q <= thr_sel;
    end

    always_ff @(posedge clk) begin
        if (flush)                 overflow <= 1'b0;
        else if (wr_valid && !acc) overflow <= 1'b1;
    end

    rxpool_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .flush(flush), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_step(rd_step), .rel_fire(rel_fire), .rel_len(rel_len),
        .acc(acc), .rd_data(rd_data), .used(used)
    );

    rxpool_seg u_seg (
        .clk(clk), .flush(flush), .thr(thr_b), .acc(acc), .last(wr_last),
        .ev_push(ev_push), .ev(ev_in)
    );

    rxpool_evq #(.DEPTH(DEPTH)) u_evq (
        .clk(clk), .flush(flush), .push(ev_push), .din(ev_in),
        .pop(ev_pop), .empty(ev_empty), .head(ev_head)
    );

    rxpool_present u_pres (
        .clk(clk), .flush(flush), .thr(thr_b), .ev_empty(ev_empty),
        .ev_head(ev_head), .cmd_release(cmd_release), .rd_en(rd_en),
        .ack_pf(ack_pf), .ack_me(ack_me), .ev_pop(ev_pop), .rd_step(rd_step),
        .rel_fire(rel_fire), .rel_len(rel_len), .rd_left(rd_left),
        .irq_pf(irq_pf), .irq_me(irq_me), .byte_cnt(byte_cnt),
        .tail_cnt(tail_cnt)
    );

    // R10: a receiver reset leaves everything visible cleared
    a_r10_rx_reset_clears: assert property (@(posedge clk) disable iff (rst)
        cmd_rx_reset |=> (!irq_pf && !irq_me && !overflow &&
                          byte_cnt == '0 && tail_cnt == '0 && rd_left == '0));
    // R9: overflow is sticky until a reset of some kind
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (flush)
        overflow |=> overflow);
endmodule

// File: tb/rxpool_fifo_tb.sv
`timescale 1ns/1ps
module rxpool_fifo_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  thr_sel = 2'b00;
    logic        cmd_rx_reset = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_last = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [6:0]  rd_left;
    logic        cmd_release = 1'b0;
    logic        ack_pf = 1'b0;
    logic        ack_me = 1'b0;
    logic        irq_pf, irq_me, overflow;
    logic [15:0] byte_cnt;
    logic [6:0]  tail_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] exp_mem [256];
    logic [7:0] exp_wr = 8'd0;
    logic [7:0] exp_rd = 8'd0;
    logic [7:0] seq = 8'd1;
    int         seg = 0;

    always #10 clk = ~clk;

    rxpool_fifo u_dut (
        .clk(clk), .rst(rst), .thr_sel(thr_sel), .cmd_rx_reset(cmd_rx_reset),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
        .rd_en(rd_en), .rd_data(rd_data), .rd_left(rd_left),
        .cmd_release(cmd_release), .ack_pf(ack_pf), .ack_me(ack_me),
        .irq_pf(irq_pf), .irq_me(irq_me), .byte_cnt(byte_cnt),
        .tail_cnt(tail_cnt), .overflow(overflow)
    );

    function automatic int thr_of(input int code);
        case (code)
            0: return 4;
            1: return 16;
            2: return 32;
            default: return 60;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // drive one byte; returns at the negedge after the capturing edge
    task automatic wr_byte(input logic [7:0] d, input logic l, input bit stored);
        wr_valid = 1'b1; wr_data = d; wr_last = l;
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0;
        if (stored) begin
            exp_mem[exp_wr] = d;
            exp_wr = exp_wr + 8'd1;
        end
    endtask

    task automatic rd_one(input string req);
        chk(req, int'(rd_data), int'(exp_mem[exp_rd]));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        exp_rd = exp_rd + 8'd1;
    endtask

    task automatic release_ack();
        cmd_release = 1'b1; ack_pf = 1'b1; ack_me = 1'b1;
        @(negedge clk);
        cmd_release = 1'b0; ack_pf = 1'b0; ack_me = 1'b0;
    endtask

    task automatic rx_reset(input logic [1:0] code);
        thr_sel = code;
        cmd_rx_reset = 1'b1;
        @(negedge clk);
        cmd_rx_reset = 1'b0;
        exp_rd = exp_wr;
        seg = 0;
    endtask

    // one frame, with the CPU serving each interrupt as it comes
    task automatic run_frame(input int len, input int t);
        for (int i = 0; i < len; i++) begin
            wr_byte(seq, (i == len - 1), 1'b1);
            seq = seq + 8'd1;
            tick();
            seg++;
            if (i == len - 1) begin
                chk("R3 me raised", int'(irq_me), 1);
                chk("R4 no pf at frame end", int'(irq_pf), 0);
                chk("R3 byte_cnt", int'(byte_cnt), len);
                chk("R4 tail_cnt", int'(tail_cnt), (seg == t) ? 0 : seg);
                chk("R3 rd_left", int'(rd_left), seg);
                for (int k = 0; k < seg; k++) rd_one("R3 tail data");
                release_ack();
                chk("R11 byte_cnt held", int'(byte_cnt), len);
                chk("R5 rd_left after release", int'(rd_left), 0);
                seg = 0;
            end else if (seg == t) begin
                chk("R2 pf raised", int'(irq_pf), 1);
                chk("R2 rd_left", int'(rd_left), t);
                for (int k = 0; k < t; k++) rd_one("R2 block data");
                release_ack();
                chk("R6 pf acked", int'(irq_pf), 0);
                seg = 0;
            end else begin
                chk("R2 no early pf", int'(irq_pf), 0);
                chk("R3 no early me", int'(irq_me), 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        // R10: reset state
        chk("R10 reset irq_pf", int'(irq_pf), 0);
        chk("R10 reset irq_me", int'(irq_me), 0);
        chk("R10 reset rd_left", int'(rd_left), 0);
        chk("R10 reset byte_cnt", int'(byte_cnt), 0);
        chk("R10 reset overflow", int'(overflow), 0);

        // R1: default 32, thr_sel change without receiver reset is ignored
        thr_sel = 2'b00;
        for (int i = 0; i < 31; i++) begin
            wr_byte(seq, 1'b0, 1'b1); seq = seq + 8'd1;
        end
        tick();
        chk("R1 no pf at 31", int'(irq_pf), 0);
        wr_byte(seq, 1'b0, 1'b1); seq = seq + 8'd1;
        tick();
        chk("R1 pf at 32", int'(irq_pf), 1);
        chk("R1 block of 32", int'(rd_left), 32);
        // three bytes beyond the block, still in the pool
        for (int i = 0; i < 3; i++) begin
            wr_byte(seq, 1'b0, 1'b1); seq = seq + 8'd1;
        end
        for (int k = 0; k < 32; k++) rd_one("R2 first block");
        // R7: surplus reads ignored
        chk("R7 rd_left empty", int'(rd_left), 0);
        rd_en = 1'b1; repeat (2) @(negedge clk); rd_en = 1'b0;
        chk("R7 rd_left stays", int'(rd_left), 0);
        chk("R7 rd_data stays", int'(rd_data), int'(exp_mem[exp_rd]));
        release_ack();
        chk("R5 no irq for partial", int'(irq_pf) + int'(irq_me), 0);
        // R8: partial read then release skips the rest
        wr_byte(seq, 1'b1, 1'b1); seq = seq + 8'd1;
        tick();
        chk("R3 me at 36", int'(irq_me), 1);
        chk("R3 byte_cnt 36", int'(byte_cnt), 36);
        chk("R3 tail 4", int'(tail_cnt), 4);
        rd_one("R8 partial read");
        release_ack();
        exp_rd = exp_rd + 8'd3;
        chk("R8 rd_left after skip", int'(rd_left), 0);
        cmd_release = 1'b1; @(negedge clk); cmd_release = 1'b0;
        tick();
        chk("R8 idle release ignored", int'(irq_pf) + int'(irq_me), 0);
        chk("R8 idle release rd_left", int'(rd_left), 0);
        chk("R11 byte_cnt after idle release", int'(byte_cnt), 36);

        // R5 / R6 with a 4-byte threshold and a 9-byte frame
        rx_reset(2'b00);
        for (int i = 0; i < 9; i++) begin
            wr_byte(seq, (i == 8), 1'b1); seq = seq + 8'd1;
        end
        tick();
        chk("R5 first pf", int'(irq_pf), 1);
        chk("R5 first rd_left", int'(rd_left), 4);
        ack_pf = 1'b1; @(negedge clk); ack_pf = 1'b0;
        repeat (3) tick();
        chk("R5 no pf before release", int'(irq_pf), 0);
        chk("R5 no me before release", int'(irq_me), 0);
        for (int k = 0; k < 4; k++) rd_one("R5 block one");
        cmd_release = 1'b1; @(negedge clk); cmd_release = 1'b0;
        tick();
        chk("R5 second pf", int'(irq_pf), 1);
        ack_me = 1'b1; @(negedge clk); ack_me = 1'b0;
        repeat (4) tick();
        chk("R6 pf survives ack_me", int'(irq_pf), 1);
        for (int k = 0; k < 4; k++) rd_one("R5 block two");
        cmd_release = 1'b1; @(negedge clk); cmd_release = 1'b0;
        tick();
        chk("R6 pf still unacked", int'(irq_pf), 1);
        chk("R3 me after second", int'(irq_me), 1);
        chk("R3 byte_cnt 9", int'(byte_cnt), 9);
        chk("R3 tail 1", int'(tail_cnt), 1);
        chk("R3 rd_left 1", int'(rd_left), 1);
        rd_one("R3 last byte");
        release_ack();
        chk("R6 both acked", int'(irq_pf) + int'(irq_me), 0);

        // R9: overflow with the 60-byte threshold
        rx_reset(2'b11);
        for (int i = 0; i < 66; i++) begin
            wr_byte(seq, 1'b0, (i < 64)); seq = seq + 8'd1;
        end
        tick();
        chk("R9 overflow set", int'(overflow), 1);
        chk("R1 pf at 60", int'(irq_pf), 1);
        chk("R1 block of 60", int'(rd_left), 60);
        for (int k = 0; k < 60; k++) rd_one("R9 stored block");
        release_ack();
        wr_byte(seq, 1'b1, 1'b1); seq = seq + 8'd1;
        tick();
        chk("R9 dropped not counted", int'(byte_cnt), 65);
        chk("R9 tail 5", int'(tail_cnt), 5);
        chk("R5 space freed", int'(rd_left), 5);
        for (int k = 0; k < 5; k++) rd_one("R9 data after drop");
        release_ack();
        chk("R9 overflow sticky", int'(overflow), 1);

        // R10: receiver reset in the middle of a frame
        wr_byte(seq, 1'b0, 1'b1); seq = seq + 8'd1;
        wr_byte(seq, 1'b0, 1'b1); seq = seq + 8'd1;
        rx_reset(2'b10);
        chk("R10 overflow cleared", int'(overflow), 0);
        chk("R10 byte_cnt cleared", int'(byte_cnt), 0);
        chk("R10 tail cleared", int'(tail_cnt), 0);
        chk("R10 rd_left cleared", int'(rd_left), 0);
        chk("R10 flags cleared", int'(irq_pf) + int'(irq_me), 0);
        run_frame(3, 32);

        // sweep: every code, every length up to two blocks plus one, one long frame
        for (int code = 0; code < 4; code++) begin
            rx_reset(2'(code));
            for (int len = 1; len <= 2 * thr_of(code) + 1; len++)
                run_frame(len, thr_of(code));
            run_frame(200, thr_of(code));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule